// File: doc/BRIEF.md
# Camera Frame Buffer Size Calculator

This block works out how much memory one received camera frame occupies when it is stored in a line-framed, packed layout. Memory is counted in 256-bit words. Each such word holds eight 32-bit words, or 32 bytes. The caller presents the following with a one-cycle start pulse:

- the pixel width,
- the line count,
- a pixel-format code,
- a flag saying whether line start and line end markers travel with each line,
- the size of the embedded data in 32-bit words.

Three rising edges later, counting the edge that samples start, the block raises done for one cycle. At that point the size output and the error flag carry the new result. Both hold until the next result.

Each line is sized in three rounding steps:

1. Bits are rounded up to bytes.
2. Bytes are rounded up to 32-bit words.
3. After the per-line header words are added, the count is rounded up to memory words.

The first line carries a frame-start word. Every later line carries its own header and, when enabled, markers. A single memory word closes the frame. In 4:2:0 formats the even lines carry twice the bit depth of the odd lines. A build parameter can pad every line with two vector lengths of extra pixels before any of this arithmetic.

Top module: `cam_fsize_calc`

## Requirements
- R1: Format codes map to bits per pixel as follows: 0→6, 1→7, 2, 3 and 4→8, 5 and 6→10, 7 and 8→12, 9→14, 10 to 13→16, 14→18, 15→20, 16→24.
- R2: Codes 17, 18, 19 and every code from 20 to 31 set err to 1 and size_words to 0 in the result.
- R3: Odd-line bytes are ceil(W×bpp/8), and 32-bit words are ceil(bytes/4). W is the width plus any padding. For codes 4 and 6 only, even lines use ceil(W×2×bpp/8) bytes. All other codes give even lines the odd-line byte count.
- R4: The first line adds 2 words, or 3 words when markers is 1. Every other line adds 1 word, or 3 words when markers is 1. Each line total is then rounded up to memory words with ceil(words/8).
- R5: size_words = ceil(emb_words/8) + first + (ceil(H/2)−1)×odd + floor(H/2)×even + 1, where first, odd and even are the line memory-word counts from R4.
- R6: A width of 0 or a height of 0 sets err to 1 and size_words to 0.
- R7: done is high for exactly one cycle. That cycle follows the third rising edge, counting the edge that samples an accepted start.
- R8: size_words and err change only together with done. Input changes made without an accepted start leave them untouched.
- R9: A start that arrives while a computation is in flight is ignored. Its inputs neither produce a result nor alter the pending one.
- R10: With PAD_MODE=1, 2×VEC_LEN pixels are added to the width before line sizing. With PAD_MODE=0, nothing is added.
- R11: A width of 65535, a height of 65535 and embedded data of 65535 words give the exact sum from R5 in every format, with no wrap.
- R12: While reset is asserted, size_words, err and done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to size a frame |
| width | input | WID_W | Pixels per line |
| height | input | HGT_W | Lines per frame |
| fmt | input | 5 | Pixel-format code |
| markers | input | 1 | 1 when lines carry start and end markers |
| emb_words | input | EMB_W | Embedded data size in 32-bit words |
| size_words | output | SIZE_W | Frame size in 256-bit memory words |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Result is invalid: unsupported format or zero dimension |

## Verification
The properties assume that the caller keeps its inputs steady only in the cycle where start is sampled. They also assume that the caller treats a start raised during a computation as lost rather than queued. The latency and zero-dimension properties look back exactly three cycles to the accepted start. The stimulus therefore issues starts from the idle state, except in one deliberate case where start is held into a busy cycle with different operands. A second instance with padding enabled receives the same stimulus, so both width paths see identical formats and sizes, including the largest widths and heights.

// File: rtl/cam_fsize_pkg.sv
package cam_fsize_pkg;
  localparam int FMT_W = 5;
  localparam int BPP_W = 5;

  typedef enum logic [FMT_W-1:0] {
    FMT_RAW6        = 5'd0,
    FMT_RAW7        = 5'd1,
    FMT_RAW8        = 5'd2,
    FMT_BIN8        = 5'd3,
    FMT_YUV420_8    = 5'd4,
    FMT_RAW10       = 5'd5,
    FMT_YUV420_10   = 5'd6,
    FMT_YUV420_8L   = 5'd7,
    FMT_RAW12       = 5'd8,
    FMT_RAW14       = 5'd9,
    FMT_RGB444      = 5'd10,
    FMT_RGB555      = 5'd11,
    FMT_RGB565      = 5'd12,
    FMT_YUV422_8    = 5'd13,
    FMT_RGB666      = 5'd14,
    FMT_YUV422_10   = 5'd15,
    FMT_RGB888      = 5'd16,
    FMT_YUV420_16   = 5'd17,
    FMT_YUV422_16   = 5'd18,
    FMT_RAW16       = 5'd19
  } pix_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LINES = 2'd1,
    ST_TOTAL = 2'd2
  } calc_state_e;

  localparam int N_LINE_KINDS = 3;
  localparam int LK_FIRST = 0;
  localparam int LK_ODD   = 1;
  localparam int LK_EVEN  = 2;
endpackage

// File: rtl/cfs_fmt_decode.sv
module cfs_fmt_decode
  import cam_fsize_pkg::*;
(
  input  logic [FMT_W-1:0] fmt,
  output logic [BPP_W-1:0] bpp,
  output logic             dbl_even,
  output logic             supported
);
  always_comb begin
    bpp       = '0;
    dbl_even  = 1'b0;
    supported = 1'b1;
    case (fmt)
      FMT_RAW6:                              bpp = 5'd6;
      FMT_RAW7:                              bpp = 5'd7;
      FMT_RAW8, FMT_BIN8:                    bpp = 5'd8;
      FMT_YUV420_8:  begin                   bpp = 5'd8;  dbl_even = 1'b1; end
      FMT_RAW10:                             bpp = 5'd10;
      FMT_YUV420_10: begin                   bpp = 5'd10; dbl_even = 1'b1; end
      FMT_YUV420_8L, FMT_RAW12:              bpp = 5'd12;
      FMT_RAW14:                             bpp = 5'd14;
      FMT_RGB444, FMT_RGB555, FMT_RGB565,
      FMT_YUV422_8:                          bpp = 5'd16;
      FMT_RGB666:                            bpp = 5'd18;
      FMT_YUV422_10:                         bpp = 5'd20;
      FMT_RGB888:                            bpp = 5'd24;
      default:                               supported = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfs_line_sizer.sv
module cfs_line_sizer #(
  parameter int PIX_W = 17,
  parameter int BPP_W = 5,
  parameter int MEM_W = 19
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [BPP_W-1:0] bpp,
  input  logic             dbl,
  input  logic [1:0]       hdr_words,
  output logic [MEM_W-1:0] mem_words
);
  localparam int BIT_W = PIX_W + BPP_W + 2;

  logic [BIT_W-1:0] line_bits;
  logic [BIT_W-1:0] line_bytes;
  logic [BIT_W-1:0] line_words;
  logic [BIT_W-1:0] framed_words;

  always_comb begin
    line_bits = BIT_W'(pix) * BIT_W'(bpp);
    if (dbl) line_bits = line_bits << 1;
    line_bytes   = (line_bits + BIT_W'(7)) >> 3;
    line_words   = (line_bytes + BIT_W'(3)) >> 2;
    framed_words = line_words + BIT_W'(hdr_words);
    mem_words    = MEM_W'((framed_words + BIT_W'(7)) >> 3);
  end
endmodule

// File: rtl/cfs_frame_sum.sv
module cfs_frame_sum #(
  parameter int HGT_W  = 16,
  parameter int EMB_W  = 16,
  parameter int MEM_W  = 19,
  parameter int SIZE_W = 32
) (
  input  logic [HGT_W-1:0]  height,
  input  logic [EMB_W-1:0]  emb_words,
  input  logic [MEM_W-1:0]  first_mw,
  input  logic [MEM_W-1:0]  odd_mw,
  input  logic [MEM_W-1:0]  even_mw,
  output logic [SIZE_W-1:0] total
);
  logic [HGT_W:0]    h_up;
  logic [HGT_W-1:0]  n_odd;
  logic [HGT_W-1:0]  n_even;
  logic [EMB_W:0]    emb_up;
  logic [SIZE_W-1:0] emb_mw;

  always_comb begin
    h_up   = {1'b0, height} + (HGT_W+1)'(1);
    n_odd  = HGT_W'(h_up >> 1) - HGT_W'(1);
    n_even = height >> 1;
    emb_up = {1'b0, emb_words} + (EMB_W+1)'(7);
    emb_mw = SIZE_W'(emb_up >> 3);
    total  = emb_mw + SIZE_W'(first_mw)
           + SIZE_W'(n_odd)  * SIZE_W'(odd_mw)
           + SIZE_W'(n_even) * SIZE_W'(even_mw)
           + SIZE_W'(1);
  end
endmodule

// File: rtl/cam_fsize_calc.sv
module cam_fsize_calc
  import cam_fsize_pkg::*;
#(
  parameter int WID_W    = 16,
  parameter int HGT_W    = 16,
  parameter int EMB_W    = 16,
  parameter int SIZE_W   = 32,
  parameter bit PAD_MODE = 1'b0,
  parameter int VEC_LEN  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WID_W-1:0]  width,
  input  logic [HGT_W-1:0]  height,
  input  logic [FMT_W-1:0]  fmt,
  input  logic              markers,
  input  logic [EMB_W-1:0]  emb_words,
  output logic [SIZE_W-1:0] size_words,
  output logic              done,
  output logic              err
);
  localparam int PIX_W   = WID_W + 1;
  localparam int PAD_PIX = 2 * VEC_LEN;
  localparam int MEM_W   = PIX_W + BPP_W + 2 - 5;

  calc_state_e       state_q, state_d;
  logic              start_ok, cap_en, line_en, res_en;
  logic [WID_W-1:0]  wid_q;
  logic [HGT_W-1:0]  hgt_q;
  logic [FMT_W-1:0]  fmt_q;
  logic              mk_q;
  logic [EMB_W-1:0]  emb_q;
  logic [MEM_W-1:0]  line_mw_d [N_LINE_KINDS];
  logic [MEM_W-1:0]  line_mw_q [N_LINE_KINDS];
  logic              bad_d, bad_q;
  logic [SIZE_W-1:0] sum_total, size_d, size_q;
  logic              err_q, done_q;
  logic [PIX_W-1:0]  pix_w;
  logic [BPP_W-1:0]  bpp;
  logic              dbl_even, supported;

  // next-state and enables
  always_comb begin
    start_ok = start && (state_q == ST_IDLE);
    cap_en   = start_ok;
    line_en  = (state_q == ST_LINES);
    res_en   = (state_q == ST_TOTAL);
    state_d  = state_q;
    case (state_q)
      ST_IDLE:  if (start_ok) state_d = ST_LINES;
      ST_LINES: state_d = ST_TOTAL;
      default:  state_d = ST_IDLE;
    endcase
  end

  generate
    if (PAD_MODE) begin : g_pad
      assign pix_w = PIX_W'(wid_q) + PIX_W'(PAD_PIX);
    end else begin : g_nopad
      assign pix_w = PIX_W'(wid_q);
    end
  endgenerate

  cfs_fmt_decode u_dec (
    .fmt       (fmt_q),
    .bpp       (bpp),
    .dbl_even  (dbl_even),
    .supported (supported)
  );

  generate
    for (genvar k = 0; k < N_LINE_KINDS; k++) begin : g_line
      logic [1:0] hdr;
      logic       dbl;
      if (k == LK_FIRST) begin : g_first
        assign hdr = mk_q ? 2'd3 : 2'd2;
      end else begin : g_later
        assign hdr = mk_q ? 2'd3 : 2'd1;
      end
      assign dbl = (k == LK_EVEN) && dbl_even;
      cfs_line_sizer #(
        .PIX_W (PIX_W),
        .BPP_W (BPP_W),
        .MEM_W (MEM_W)
      ) u_line (
        .pix       (pix_w),
        .bpp       (bpp),
        .dbl       (dbl),
        .hdr_words (hdr),
        .mem_words (line_mw_d[k])
      );
    end
  endgenerate

  assign bad_d = !supported || (wid_q == '0) || (hgt_q == '0);

  cfs_frame_sum #(
    .HGT_W  (HGT_W),
    .EMB_W  (EMB_W),
    .MEM_W  (MEM_W),
    .SIZE_W (SIZE_W)
  ) u_sum (
    .height    (hgt_q),
    .emb_words (emb_q),
    .first_mw  (line_mw_q[LK_FIRST]),
    .odd_mw    (line_mw_q[LK_ODD]),
    .even_mw   (line_mw_q[LK_EVEN]),
    .total     (sum_total)
  );

  assign size_d = bad_q ? '0 : sum_total;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wid_q   <= '0;
      hgt_q   <= '0;
      fmt_q   <= '0;
      mk_q    <= 1'b0;
      emb_q   <= '0;
      bad_q   <= 1'b0;
      size_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      for (int k = 0; k < N_LINE_KINDS; k++) line_mw_q[k] <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= res_en;
      if (cap_en) begin
        wid_q <= width;
        hgt_q <= height;
        fmt_q <= fmt;
        mk_q  <= markers;
        emb_q <= emb_words;
      end
      if (line_en) begin
        bad_q <= bad_d;
        for (int k = 0; k < N_LINE_KINDS; k++) line_mw_q[k] <= line_mw_d[k];
      end
      if (res_en) begin
        size_q <= size_d;
        err_q  <= bad_q;
      end
    end
  end

  assign size_words = size_q;
  assign done       = done_q;
  assign err        = err_q;
endmodule

// File: rtl/cfs_calc_chk.sv
module cfs_calc_chk #(
  parameter int WID_W  = 16,
  parameter int HGT_W  = 16,
  parameter int SIZE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_ok,
  input logic [WID_W-1:0]  width,
  input logic [HGT_W-1:0]  height,
  input logic [SIZE_W-1:0] size_words,
  input logic              done,
  input logic              err
);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start_ok, 3));

  assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!$past(start_ok, 1) && !$past(start_ok, 2)));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(size_words) && $stable(err)));

  assert_err_zero_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (size_words == '0));

  assert_zero_dim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (($past(width, 3) == '0) || ($past(height, 3) == '0))) |-> err);

  assert_min_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (size_words >= SIZE_W'(2)));
endmodule

bind cam_fsize_calc cfs_calc_chk #(
  .WID_W  (WID_W),
  .HGT_W  (HGT_W),
  .SIZE_W (SIZE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_ok   (start_ok),
  .width      (width),
  .height     (height),
  .size_words (size_words),
  .done       (done),
  .err        (err)
);

// File: tb/test_cam_fsize_calc.sv
`timescale 1ns/1ps
module test_cam_fsize_calc;
  localparam int PAD = 64;

  typedef struct packed {
    logic [31:0] size;
    logic        err;
    logic [31:0] due;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] width = '0;
  logic [15:0] height = '0;
  logic [4:0]  fmt = '0;
  logic        markers = 1'b0;
  logic [15:0] emb_words = '0;
  logic [31:0] s0, s1;
  logic        d0, d1, e0, e1;

  int   total = 0, bad = 0, cyc = 0;
  exp_t q0[$], q1[$];
  string t0[$], t1[$];
  logic [31:0] last_s0;
  logic        last_e0;
  bit   prev0 = 0, prev1 = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cam_fsize_calc i_cam_fsize_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .width(width), .height(height),
    .fmt(fmt), .markers(markers), .emb_words(emb_words),
    .size_words(s0), .done(d0), .err(e0));

  cam_fsize_calc #(.PAD_MODE(1'b1), .VEC_LEN(32)) i_cam_fsize_calc_pad (
    .clk(clk), .rst_n(rst_n), .start(start), .width(width), .height(height),
    .fmt(fmt), .markers(markers), .emb_words(emb_words),
    .size_words(s1), .done(d1), .err(e1));

  function automatic exp_t model(int w, int h, int f, bit m, int e, int pad);
    exp_t   r;
    int     bpp;
    bit     y420;
    longint pw, ob, eb, ow, ew, fm, om, em, sz;
    y420 = (f == 4) || (f == 6);
    case (f)
      0: bpp = 6;   1: bpp = 7;   2, 3, 4: bpp = 8;  5, 6: bpp = 10;
      7, 8: bpp = 12;  9: bpp = 14;  10, 11, 12, 13: bpp = 16;
      14: bpp = 18; 15: bpp = 20; 16: bpp = 24; default: bpp = 0;
    endcase
    r = '0;
    if (bpp == 0 || w == 0 || h == 0) begin
      r.err = 1'b1;
      return r;
    end
    pw = w + pad;
    ob = (pw * bpp + 7) / 8;
    eb = y420 ? (pw * 2 * bpp + 7) / 8 : ob;
    ow = (ob + 3) / 4;
    ew = (eb + 3) / 4;
    fm = (ow + (m ? 3 : 2) + 7) / 8;
    om = (ow + (m ? 3 : 1) + 7) / 8;
    em = (ew + (m ? 3 : 1) + 7) / 8;
    sz = (e + 7) / 8 + fm + ((h + 1) / 2 - 1) * om + (h / 2) * em + 1;
    r.size = sz[31:0];
    return r;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic judge(exp_t x, string tag, logic [31:0] sz, logic er);
    check(sz == x.size, tag, "size", sz, x.size);
    check(er == x.err, tag, "err", er, x.err);
    check(cyc == x.due, {tag, " R7"}, "done cycle", cyc, x.due);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (d0) begin
        if (q0.size() == 0) check(0, "R9", "unexpected done", 1, 0);
        else judge(q0.pop_front(), t0.pop_front(), s0, e0);
        last_s0 = s0;
        last_e0 = e0;
      end
      if (d0 && prev0) check(0, "R7", "done width", 2, 1);
      prev0 = d0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (d1) begin
        if (q1.size() == 0) check(0, "R9", "unexpected done (pad)", 1, 0);
        else judge(q1.pop_front(), t1.pop_front(), s1, e1);
      end
      if (d1 && prev1) check(0, "R7", "done width (pad)", 2, 1);
      prev1 = d1;
    end
  end

  task automatic launch(int w, int h, int f, bit m, int e, string tag, bit busy2 = 0);
    exp_t x;
    @(negedge clk);
    width = w[15:0]; height = h[15:0]; fmt = f[4:0]; markers = m; emb_words = e[15:0];
    start = 1'b1;
    x = model(w, h, f, m, e, 0);   x.due = cyc + 3; q0.push_back(x); t0.push_back(tag);
    x = model(w, h, f, m, e, PAD); x.due = cyc + 3; q1.push_back(x); t1.push_back({tag, " R10"});
    if (busy2) begin
      @(negedge clk);
      width = 16'(w + 5); fmt = 5'd16; height = 16'd3; markers = ~m;
    end
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(s0 == 0, "R12", "size in reset", s0, 0);
    check(e0 == 0, "R12", "err in reset", e0, 0);
    check(d0 == 0, "R12", "done in reset", d0, 0);
    #1.3 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    launch(100, 4, 2, 0, 0, "R5 raw8");
    launch(50, 7, 4, 1, 20, "R3 yuv420-8");
    launch(33, 5, 6, 0, 3, "R3 yuv420-10");
    launch(13, 1, 0, 1, 0, "R4 raw6 one line");
    launch(9, 2, 1, 0, 7, "R4 raw7");
    launch(77, 3, 14, 1, 9, "R1 rgb666");
    for (int f = 0; f <= 16; f++) launch(21, 6, f, f[0], f * 3, "R1 sweep");
    launch(65535, 65535, 16, 1, 65535, "R11 rgb888 max");
    launch(65535, 65535, 6, 1, 65535, "R11 yuv420-10 max");
    launch(65535, 65535, 15, 0, 65535, "R11 yuv422-10 max");
    launch(40, 4, 17, 0, 0, "R2 code17");
    launch(40, 4, 18, 1, 0, "R2 code18");
    launch(40, 4, 19, 0, 0, "R2 code19");
    launch(40, 4, 27, 0, 0, "R2 code27");
    launch(0, 4, 2, 0, 0, "R6 zero width");
    launch(40, 0, 2, 0, 0, "R6 zero height");
    launch(64, 8, 13, 0, 0, "R9 busy start", 1'b1);

    // R8: inputs move without start, result must hold
    @(negedge clk);
    width = 16'd999; height = 16'd77; fmt = 5'd16; emb_words = 16'd500;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(s0 == last_s0, "R8", "size held", s0, last_s0);
      check(e0 == last_e0, "R8", "err held", e0, last_e0);
      check(d0 == 0, "R8", "no done", d0, 0);
    end

    repeat (4) @(negedge clk);
    check(q0.size() == 0, "R7", "pending results", q0.size(), 0);
    check(q1.size() == 0, "R10", "pending results (pad)", q1.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule